// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block holds stores between address generation and their write to the data cache. A store enters the buffer once both its address and its data are present. It is marked committed when the pipeline retires it without exception or misprediction. It is written to the cache only after that, oldest first, and only in a cycle in which the memory write port is granted. A flush discards every store that has not been committed. Committed stores are still written to the cache after a flush.

A load presents its address on the lookup port, and the address is compared with every store in the buffer. When one or more stores match, the data of the youngest matching store is returned, and the load is forwarded. When no store matches, the load is told it may read the cache, and it bypasses the buffer. Every store in the buffer is treated as older than the load that looks it up. Addresses are compared as whole words.

The buffer is a circular queue with three pointers: head (oldest), commit boundary and tail. The committed stores are always the contiguous run that starts at head.

Top module: `store_buffer_fwd`

## Requirements
- R1: A store is accepted in a cycle only when `st_addr_vld` and `st_data_vld` are both 1, `full` is 0 and `flush` is 0. In any other cycle the store inputs have no effect.
- R2: `full` is 1 exactly when DEPTH stores are held. `empty` is 1 exactly when no store is held.
- R3: A `commit` pulse marks the oldest uncommitted store as committed. A pulse when every held store is already committed has no effect.
- R4: `mem_req` is 1 exactly when the oldest held store is committed. `mem_addr` and `mem_data` then carry that store's address and data. While `mem_grant` is 0 they stay stable.
- R5: In a cycle with `mem_req` and `mem_grant` both 1, the oldest store leaves the buffer, so stores reach the cache in program order.
- R6: `flush` removes every uncommitted store at the next edge. A store committed in the same cycle as the flush is kept.
- R7: With `ld_valid` at 1 and at least one held store whose address equals `ld_addr`, `ld_fwd` is 1. `ld_data` is then the data of the youngest such store, which is the one accepted last.
- R8: With `ld_valid` at 1 and no matching store, `ld_bypass` is 1 and `ld_fwd` is 0. With `ld_valid` at 0, both are 0.
- R9: After reset the buffer is empty, `mem_req` is 0 and no load is forwarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_addr_vld | input | 1 | Store address present |
| st_data_vld | input | 1 | Store data present |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| full | output | 1 | Buffer holds DEPTH stores |
| empty | output | 1 | Buffer holds no store |
| commit | input | 1 | Retire the oldest uncommitted store |
| flush | input | 1 | Discard all uncommitted stores |
| mem_req | output | 1 | Oldest store is committed and ready to write |
| mem_addr | output | AW | Address of the oldest store |
| mem_data | output | DW | Data of the oldest store |
| mem_grant | input | 1 | Cache write port granted this cycle |
| ld_valid | input | 1 | Load lookup active |
| ld_addr | input | AW | Load address |
| ld_fwd | output | 1 | A held store matches; use `ld_data` |
| ld_bypass | output | 1 | No store matches; read the cache |
| ld_data | output | DW | Data of the youngest matching store |

## Verification
The hardest situations are those where the buffer wraps around its storage while several stores share an address. In these, the youngest match sits at a lower slot index than an older match, and a flush moves the tail back across the wrap point. The bench uses a 4-entry configuration with a 3-bit address space, so repeated addresses are common. It drives commit, flush, grant and the two valid bits in randomised mixes, with phases biased towards a full buffer and towards frequent flushes. In every cycle it sweeps all eight load addresses against a queue model.

// File: rtl/sq_pkg.sv
package sq_pkg;
    localparam int SQ_DEPTH = 32;
    localparam int SQ_AW    = 32;
    localparam int SQ_DW    = 32;

    typedef enum logic [1:0] {
        LK_IDLE    = 2'd0,
        LK_BYPASS  = 2'd1,
        LK_FORWARD = 2'd2
    } lookup_e;

    function automatic lookup_e classify(input logic valid, input logic hit);
        if (!valid)   return LK_IDLE;
        else if (hit) return LK_FORWARD;
        else          return LK_BYPASS;
    endfunction
endpackage

// File: rtl/sq_ptr_ctrl.sv
module sq_ptr_ctrl #(
    parameter int DEPTH = 32,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          alloc_req,
    input  logic          commit_req,
    input  logic          flush,
    input  logic          grant,
    output logic [PW-1:0] head_idx,
    output logic [PW-1:0] tail_idx,
    output logic [PW:0]   occupancy,
    output logic          accept,
    output logic          mem_pending,
    output logic          mem_fire,
    output logic          full,
    output logic          empty
);
    logic [PW:0] head_q, cmt_q, tail_q;
    logic [PW:0] cmt_nxt, n_committed;
    logic        commit_ok;

    always_comb begin
        occupancy   = tail_q - head_q;
        n_committed = cmt_q - head_q;
        full        = (occupancy == (PW+1)'(DEPTH));
        empty       = (occupancy == '0);
        mem_pending = (n_committed != '0);
        mem_fire    = mem_pending && grant;
        commit_ok   = commit_req && (cmt_q != tail_q);
        accept      = alloc_req && !full && !flush;
        cmt_nxt     = cmt_q + (PW+1)'(commit_ok);
        head_idx    = head_q[PW-1:0];
        tail_idx    = tail_q[PW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            cmt_q  <= '0;
            tail_q <= '0;
        end else begin
            head_q <= head_q + (PW+1)'(mem_fire);
            cmt_q  <= cmt_nxt;
            tail_q <= flush ? cmt_nxt : tail_q + (PW+1)'(accept);
        end
    end

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        occupancy <= (PW+1)'(DEPTH));

    // R1
    full_blocks_alloc_chk: assert property (@(posedge clk) disable iff (rst)
        (full && !flush) |=> tail_q == $past(tail_q));

    // R3
    commit_inside_chk: assert property (@(posedge clk) disable iff (rst)
        (cmt_q - head_q) <= (tail_q - head_q));

    // R5
    drain_order_chk: assert property (@(posedge clk) disable iff (rst)
        mem_fire |=> head_q == $past(head_q) + 1'b1);

    // R6
    flush_trim_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> tail_q == cmt_q);
endmodule

// File: rtl/sq_fwd_search.sv
module sq_fwd_search #(
    parameter int DEPTH = 32,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0][AW-1:0] slot_addr,
    input  logic [DEPTH-1:0][DW-1:0] slot_data,
    input  logic [PW-1:0]            head_idx,
    input  logic [PW:0]              occupancy,
    input  logic [AW-1:0]            ld_addr,
    output logic                     hit,
    output logic [DW-1:0]            hit_data
);
    // Walk from oldest to youngest; a later match overrides an earlier one.
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            logic [PW-1:0] idx;
            idx = head_idx + PW'(k);
            if (((PW+1)'(k) < occupancy) && (slot_addr[idx] == ld_addr)) begin
                hit      = 1'b1;
                hit_data = slot_data[idx];
            end
        end
    end
endmodule

// File: rtl/store_buffer_fwd.sv
module store_buffer_fwd
    import sq_pkg::*;
#(
    parameter int DEPTH = SQ_DEPTH,
    parameter int AW    = SQ_AW,
    parameter int DW    = SQ_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          st_addr_vld,
    input  logic          st_data_vld,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    output logic          full,
    output logic          empty,
    input  logic          commit,
    input  logic          flush,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_data,
    input  logic          mem_grant,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    output logic          ld_fwd,
    output logic          ld_bypass,
    output logic [DW-1:0] ld_data
);
    localparam int PW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } entry_t;

    entry_t                  slots [DEPTH];
    logic [DEPTH-1:0][AW-1:0] slot_addr;
    logic [DEPTH-1:0][DW-1:0] slot_data;
    logic [PW-1:0]           head_idx, tail_idx;
    logic [PW:0]             occupancy;
    logic                    accept, mem_fire, hit;
    logic [DW-1:0]           hit_data;
    lookup_e                 lk;

    sq_ptr_ctrl #(.DEPTH(DEPTH)) ptr_i (
        .clk        (clk),
        .rst        (rst),
        .alloc_req  (st_addr_vld && st_data_vld),
        .commit_req (commit),
        .flush      (flush),
        .grant      (mem_grant),
        .head_idx   (head_idx),
        .tail_idx   (tail_idx),
        .occupancy  (occupancy),
        .accept     (accept),
        .mem_pending(mem_req),
        .mem_fire   (mem_fire),
        .full       (full),
        .empty      (empty)
    );

    always_ff @(posedge clk) begin
        if (accept) slots[tail_idx] <= '{addr: st_addr, data: st_data};
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            slot_addr[i] = slots[i].addr;
            slot_data[i] = slots[i].data;
        end
    end

    sq_fwd_search #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) srch_i (
        .slot_addr(slot_addr),
        .slot_data(slot_data),
        .head_idx (head_idx),
        .occupancy(occupancy),
        .ld_addr  (ld_addr),
        .hit      (hit),
        .hit_data (hit_data)
    );

    always_comb begin
        mem_addr  = slots[head_idx].addr;
        mem_data  = slots[head_idx].data;
        lk        = classify(ld_valid, hit);
        ld_fwd    = (lk == LK_FORWARD);
        ld_bypass = (lk == LK_BYPASS);
        ld_data   = hit_data;
    end

    // R4
    drain_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_grant) |=> mem_req && $stable(mem_addr) && $stable(mem_data));

    // R8
    lookup_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ld_fwd && ld_bypass) && (ld_valid || (!ld_fwd && !ld_bypass)));

    // R7
    hit_needs_entry_chk: assert property (@(posedge clk) disable iff (rst)
        ld_fwd |-> !empty);

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> empty && !mem_req);
endmodule

// File: tb/store_buffer_fwd_tb.sv
`timescale 1ns/10ps
module store_buffer_fwd_tb_top;
    localparam int DEPTH = 4;
    localparam int AW    = 3;
    localparam int DW    = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic st_addr_vld = 0, st_data_vld = 0, commit = 0, flush = 0, mem_grant = 0, ld_valid = 0;
    logic [AW-1:0] st_addr = '0, ld_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic full, empty, mem_req, ld_fwd, ld_bypass;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data, ld_data;

    always #4 clk = ~clk;

    store_buffer_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst(rst),
        .st_addr_vld(st_addr_vld), .st_data_vld(st_data_vld),
        .st_addr(st_addr), .st_data(st_data),
        .full(full), .empty(empty),
        .commit(commit), .flush(flush),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_grant(mem_grant),
        .ld_valid(ld_valid), .ld_addr(ld_addr),
        .ld_fwd(ld_fwd), .ld_bypass(ld_bypass), .ld_data(ld_data)
    );

    logic [AW+DW-1:0] mq[$];
    int    ncmt = 0;
    int    errs = 0;
    int    chks = 0;
    bit    done = 0;
    string ctx  = "R2";
    logic [DW-1:0] dseq = 8'h10;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        chks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check outputs, advance the model.
    task automatic step(input bit av, input bit dv, input bit cm,
                        input bit fl, input bit gr, input logic [AW-1:0] a);
        bit cmt_ok, drain, acc;
        @(negedge clk);
        st_addr_vld = av; st_data_vld = dv; commit = cm; flush = fl;
        mem_grant = gr; st_addr = a; st_data = dseq; dseq = dseq + 8'd7;
        #0.2;
        // ctx names what the previous cycle exercised (R1, R3, R5, R6)
        chk(full  == (mq.size() == DEPTH), {ctx, "/R2"}, "full",  32'(full),  32'(mq.size() == DEPTH));
        chk(empty == (mq.size() == 0),     {ctx, "/R2"}, "empty", 32'(empty), 32'(mq.size() == 0));
        chk(mem_req == (ncmt > 0), {ctx, "/R4"}, "mem_req", 32'(mem_req), 32'(ncmt > 0));
        if (ncmt > 0) begin
            chk(mem_addr == mq[0][AW+DW-1:DW], "R4", "mem_addr", 32'(mem_addr), 32'(mq[0][AW+DW-1:DW]));
            chk(mem_data == mq[0][DW-1:0],     "R4", "mem_data", 32'(mem_data), 32'(mq[0][DW-1:0]));
        end
        for (int la = 0; la < (1 << AW); la++) begin
            bit            eh = 0;
            logic [DW-1:0] ed = '0;
            ld_addr = AW'(la); ld_valid = 1'b1;
            #0.2;
            foreach (mq[i]) if (mq[i][AW+DW-1:DW] == AW'(la)) begin eh = 1; ed = mq[i][DW-1:0]; end
            chk(ld_fwd == eh,     "R7", "ld_fwd",    32'(ld_fwd),    32'(eh));
            chk(ld_bypass == !eh, "R8", "ld_bypass", 32'(ld_bypass), 32'(!eh));
            if (eh) chk(ld_data == ed, "R7", "ld_data", 32'(ld_data), 32'(ed));
        end
        ld_valid = 1'b0;
        #0.2;
        chk(!ld_fwd && !ld_bypass, "R8", "idle lookup", {ld_fwd, ld_bypass}, 32'd0);
        // model update
        cmt_ok = cm && (ncmt < mq.size());
        drain  = gr && (ncmt > 0);
        acc    = av && dv && (mq.size() < DEPTH) && !fl;
        ncmt   = ncmt + int'(cmt_ok);
        if (fl) while (mq.size() > ncmt) void'(mq.pop_back());
        else if (acc) mq.push_back({a, st_data});
        if (drain) begin void'(mq.pop_front()); ncmt--; end
        if (fl)          ctx = "R6";
        else if (drain)  ctx = "R5";
        else if (cm)     ctx = "R3";
        else             ctx = "R1";
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, chks);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errs++; chks++;
            $display("FAIL watchdog: actual=hung expected=done");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #0.2;
        // R9 reset state
        chk(empty && !full, "R9", "empty/full", {empty, full}, 32'd2);
        chk(!mem_req, "R9", "mem_req", 32'(mem_req), 32'd0);
        ld_valid = 1'b1; ld_addr = '0; #0.2;
        chk(!ld_fwd && ld_bypass, "R9", "lookup", {ld_fwd, ld_bypass}, 32'd1);
        ld_valid = 1'b0;
        // R1: only one valid bit -> not accepted
        step(1, 0, 0, 0, 0, 3'd1);
        step(0, 1, 0, 0, 0, 3'd1);
        // fill with same address, then try while full (R1, R2, R7)
        for (int i = 0; i < DEPTH + 2; i++) step(1, 1, 0, 0, 0, 3'd5);
        // commit two, flush with a third commit in same cycle (R3, R6)
        step(0, 0, 1, 0, 0, 3'd0);
        step(0, 0, 1, 0, 0, 3'd0);
        step(1, 1, 1, 1, 0, 3'd2);
        // extra commits with nothing left to commit (R3)
        step(0, 0, 1, 0, 0, 3'd0);
        step(0, 0, 1, 0, 0, 3'd0);
        // drain with stalls (R4, R5)
        step(0, 0, 0, 0, 0, 3'd0);
        for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 1, 3'd0);
        // randomised phases (wrap-around, repeated addresses)
        for (int ph = 0; ph < 4; ph++) begin
            for (int n = 0; n < 1500; n++) begin
                int pa, pc, pf, pg;
                pa = (ph == 1) ? 90 : 60;
                pc = (ph == 2) ? 25 : 50;
                pf = (ph == 2) ? 15 : 4;
                pg = (ph == 1) ? 20 : 50;
                step($urandom_range(99) < pa, $urandom_range(99) < pa + 5,
                     $urandom_range(99) < pc, $urandom_range(99) < pf,
                     $urandom_range(99) < pg, AW'($urandom_range((1 << AW) - 1)));
            end
        end
        done = 1;
        summary();
    end
endmodule